// File: doc/BRIEF.md
# Multiplexed-stream correlated sampling processor

This block takes four parallel converter streams. Each stream interleaves eight detector channels, one word per slot, so one pass of the eight slots covers 32 channels in one 500 ns sample period. A slot counter, forced back to zero by a frame-start marker, gives each incoming 10-bit word its channel number (stream × 8 + slot). For every channel the block keeps the last word it saw. It forms the signed difference between the new word and the stored one, which is the dual correlated sample, and then overwrites the stored word.

A difference that reaches a programmable signed threshold becomes a hit record. The record holds the channel number, a 32-bit count of completed sample periods, the difference and the raw new word. Up to four hits can appear in one accepted slot, one per stream. They enter a small output FIFO in ascending stream order, and a valid/ready pair drains it one record at a time. The block runs without pause: there is no acquire phase and no readout phase, so live time is full.

Top module: `mux_dcs_proc`

## Requirements
- R1: After reset, `out_valid` and `ovf` are both 0.
- R2: A word accepted with `frame_start` high is slot 0. Otherwise its slot is one more than the slot of the previous accepted word, wrapping from 7 to 0. Stream s bits [10s+9:10s] of `s_data` belong to channel s*8+slot, and this number is reported on `out_chan`.
- R3: The first word each channel receives after reset produces no record. It only loads the stored value for that channel.
- R4: `out_diff` is the new word minus the stored word of the same channel, as 11-bit two's complement, and `out_sample` is the new word.
- R5: A record is produced only when `out_diff` is greater than or equal to the signed 11-bit `thresh`. A difference equal to `thresh` produces a record.
- R6: `out_period` equals the number of accepted slot-7 words that came before the word producing the record.
- R7: Hits from the same accepted slot leave the block in ascending stream order.
- R8: A hit that finds the 8-entry FIFO full is discarded and sets `ovf`. `ovf` stays set until reset. Records already held are not disturbed.
- R9: While `smp_en` is low, `s_data` and `frame_start` are ignored: no record is produced and the slot does not advance.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all record fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One word per stream present this cycle |
| frame_start | input | 1 | Current word is slot 0 |
| s_data | input | 40 | Four 10-bit words, stream 0 in the low bits |
| thresh | input | 11 | Signed hit threshold |
| out_ready | input | 1 | Consumer takes the head record |
| out_valid | output | 1 | Head record available |
| out_chan | output | 5 | Channel number |
| out_period | output | 32 | Sample period count |
| out_diff | output | 11 | Signed correlated difference |
| out_sample | output | 10 | Raw new word |
| ovf | output | 1 | Sticky record-loss flag |

## Verification
The assertions assume that `smp_en`, `frame_start` and `out_ready` are known whenever reset is released, and that `thresh` changes only while no word is being accepted. The stimulus drives every input on the falling edge and changes the threshold only between frames. It spaces accepted words three idle cycles apart while the consumer is ready, so that loss happens only in the one scenario that stalls the consumer on purpose.

// File: rtl/mux_dcs_proc.sv
module mux_dcs_proc #(
  parameter int NSTREAM = 4,
  parameter int NSLOT   = 8,
  parameter int DW      = 10,
  parameter int TSW     = 32,
  parameter int FDEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_en,
  input  logic                      frame_start,
  input  logic [NSTREAM*DW-1:0]     s_data,
  input  logic [DW:0]               thresh,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [$clog2(NSTREAM*NSLOT)-1:0] out_chan,
  output logic [TSW-1:0]            out_period,
  output logic [DW:0]               out_diff,
  output logic [DW-1:0]             out_sample,
  output logic                      ovf
);
  localparam int SW  = $clog2(NSLOT);
  localparam int NCH = NSTREAM * NSLOT;
  localparam int CW  = $clog2(NCH);
  localparam int XW  = DW + 1;
  localparam int RW  = CW + TSW + XW + DW;
  localparam int PW  = $clog2(FDEPTH);
  localparam int KW  = $clog2(FDEPTH + 1);
  localparam int HW  = $clog2(NSTREAM + 1);

  logic [SW-1:0]  slot_q;
  logic [TSW-1:0] period_q;
  logic [DW-1:0]  prev_q [NCH];
  logic [NCH-1:0] primed_q;
  logic           ovf_q;

  logic [RW-1:0]  mem [FDEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [KW-1:0]  count_q;

  wire [SW-1:0] slot   = frame_start ? '0 : slot_q;
  wire          pop    = out_valid && out_ready;
  wire [KW-1:0] free_n = KW'(FDEPTH) - count_q;

  logic [CW-1:0]      ch    [NSTREAM];
  logic [XW-1:0]      diff  [NSTREAM];
  logic [RW-1:0]      rec   [NSTREAM];
  logic [NSTREAM-1:0] hit;
  logic [NSTREAM-1:0] wr_ok;
  logic [HW-1:0]      rank  [NSTREAM];

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    localparam logic [CW-1:0] BASE = CW'(s * NSLOT);
    wire [DW-1:0] cur = s_data[s*DW +: DW];
    assign ch[s]   = BASE + CW'(slot);
    assign diff[s] = {1'b0, cur} - {1'b0, prev_q[ch[s]]};
    assign hit[s]  = smp_en && primed_q[ch[s]] && ($signed(diff[s]) >= $signed(thresh));
    assign rec[s]  = {ch[s], period_q, diff[s], cur};
  end

  always_comb begin
    for (int s = 0; s < NSTREAM; s++) begin
      rank[s] = '0;
      for (int k = 0; k < s; k++) rank[s] = rank[s] + HW'(hit[k]);
      wr_ok[s] = hit[s] && (KW'(rank[s]) < free_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      period_q <= '0;
      primed_q <= '0;
    end else if (smp_en) begin
      slot_q <= slot + SW'(1);
      if (slot == SW'(NSLOT - 1)) period_q <= period_q + TSW'(1);
      for (int s = 0; s < NSTREAM; s++) primed_q[ch[s]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (smp_en)
      for (int s = 0; s < NSTREAM; s++) prev_q[ch[s]] <= s_data[s*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wr_ptr  <= wr_ptr + PW'($countones(wr_ok));
      rd_ptr  <= rd_ptr + PW'(pop);
      count_q <= count_q + KW'($countones(wr_ok)) - KW'(pop);
      ovf_q   <= ovf_q | (|(hit & ~wr_ok));
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTREAM; s++)
      if (wr_ok[s]) mem[wr_ptr + PW'(rank[s])] <= rec[s];
  end

  assign out_valid = (count_q != '0);
  assign {out_chan, out_period, out_diff, out_sample} = mem[rd_ptr];
  assign ovf = ovf_q;
endmodule

// File: rtl/mux_dcs_chk.sv
module mux_dcs_chk #(
  parameter int NSLOT  = 8,
  parameter int TSW    = 32,
  parameter int RW     = 58,
  parameter int FDEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_en,
  input logic                       frame_start,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [RW-1:0]              out_rec,
  input logic                       ovf,
  input logic [$clog2(NSLOT)-1:0]   slot_q,
  input logic [TSW-1:0]             period_q,
  input logic [$clog2(FDEPTH+1)-1:0] count_q
);
  localparam int SW = $clog2(NSLOT);

  // R2
  slot_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && frame_start |=> slot_q == SW'(1));

  // R6
  period_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && !frame_start && slot_q == SW'(NSLOT - 1) |=> period_q == $past(period_q) + TSW'(1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(slot_q) && $stable(period_q));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= ($clog2(FDEPTH+1))'(FDEPTH));

  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rec));
endmodule

bind mux_dcs_proc mux_dcs_chk #(
  .NSLOT(NSLOT), .TSW(TSW), .RW(RW), .FDEPTH(FDEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .frame_start(frame_start),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_rec({out_chan, out_period, out_diff, out_sample}), .ovf(ovf),
  .slot_q(slot_q), .period_q(period_q), .count_q(count_q)
);

// File: tb/tb_mux_dcs_proc.sv
module tb_mux_dcs_proc;
  localparam int CLK_PERIOD = 10;
  localparam int FDEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic        frame_start = 1'b0;
  logic [39:0] s_data = '0;
  logic [10:0] thresh = 11'h400;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [4:0]  out_chan;
  logic [31:0] out_period;
  logic [10:0] out_diff;
  logic [9:0]  out_sample;
  logic        ovf;

  mux_dcs_proc dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [57:0] expq[$];
  logic [9:0]  bprev [32];
  bit          bprimed [32];
  int          bslot = 0;
  logic [31:0] bperiod = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0)
        chk(1'b0, "R3/R5 unexpected record", {out_chan, out_period, out_diff, out_sample}, 64'h0);
      else begin
        logic [57:0] e;
        e = expq.pop_front();
        chk({out_chan, out_period, out_diff, out_sample} == e, "R2/R4/R6/R7 record",
            {out_chan, out_period, out_diff, out_sample}, e);
      end
    end
  end

  task automatic send_word(input bit fs, input logic [39:0] d, input int gap);
    int sl;
    sl = fs ? 0 : bslot;
    for (int s = 0; s < 4; s++) begin
      int ch;
      logic [9:0] cur;
      logic [10:0] df;
      ch = s * 8 + sl;
      cur = d[s*10 +: 10];
      df = {1'b0, cur} - {1'b0, bprev[ch]};
      if (bprimed[ch] && $signed(df) >= $signed(thresh)) begin
        if (expq.size() < FDEPTH || out_ready) expq.push_back({5'(ch), bperiod, df, cur});
      end
      bprev[ch] = cur;
      bprimed[ch] = 1'b1;
    end
    if (sl == 7) bperiod = bperiod + 1;
    bslot = (sl + 1) % 8;
    smp_en = 1'b1; frame_start = fs; s_data = d;
    @(negedge clk);
    smp_en = 1'b0; frame_start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [39:0] pat(input int seed, input int sl);
    logic [39:0] d;
    for (int s = 0; s < 4; s++) d[s*10 +: 10] = 10'((seed * 37 + s * 101 + sl * 13) % 1024);
    return d;
  endfunction

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 200) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2/R7 all records delivered", 64'(expq.size()), 64'h0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
    chk(ovf == 1'b0, "R1 ovf after reset", 64'(ovf), 64'h0);
  endtask

  task automatic t_prime();
    thresh = 11'h400;
    for (int sl = 0; sl < 8; sl++) send_word(sl == 0, pat(1, sl), 3);
    drain();
    chk(out_valid == 1'b0, "R3 no record on first samples", 64'(out_valid), 64'h0);
  endtask

  task automatic t_full_frames();
    thresh = 11'h400;
    for (int f = 2; f < 5; f++)
      for (int sl = 0; sl < 8; sl++) send_word(sl == 0, pat(f, sl), 3);
    drain();
  endtask

  task automatic t_threshold();
    thresh = 11'h400;
    for (int sl = 0; sl < 8; sl++) send_word(sl == 0, {4{10'd500}}, 3);
    drain();
    thresh = 11'd2;
    for (int sl = 0; sl < 8; sl++) begin
      logic [39:0] d;
      for (int s = 0; s < 4; s++) d[s*10 +: 10] = 10'(500 + sl - 3 + s);
      send_word(sl == 0, d, 3);
    end
    drain();
  endtask

  task automatic t_extremes();
    thresh = 11'h400;
    for (int sl = 0; sl < 8; sl++) send_word(sl == 0, {10'd0, 10'd1023, 10'd0, 10'd1023}, 3);
    for (int sl = 0; sl < 8; sl++) send_word(sl == 0, {10'd1023, 10'd0, 10'd1023, 10'd0}, 3);
    drain();
  endtask

  task automatic t_resync();
    thresh = 11'h400;
    for (int sl = 0; sl < 3; sl++) send_word(1'b0, pat(7, sl), 3);
    for (int sl = 0; sl < 8; sl++) send_word(sl == 0, pat(8, sl), 3);
    drain();
  endtask

  task automatic t_idle();
    thresh = 11'h400;
    send_word(1'b1, pat(9, 0), 3);
    drain();
    frame_start = 1'b1; s_data = pat(10, 0);
    repeat (5) @(negedge clk);
    frame_start = 1'b0;
    chk(out_valid == 1'b0, "R9 ignored while smp_en low", 64'(out_valid), 64'h0);
    send_word(1'b0, pat(11, 1), 3);
    drain();
  endtask

  task automatic t_backpressure();
    logic [57:0] held;
    thresh = 11'h400;
    out_ready = 1'b0;
    for (int w = 0; w < 3; w++) send_word(1'b0, pat(12 + w, w), 0);
    chk(ovf == 1'b1, "R8 ovf after loss", 64'(ovf), 64'h1);
    chk(out_valid == 1'b1, "R10 valid while stalled", 64'(out_valid), 64'h1);
    held = {out_chan, out_period, out_diff, out_sample};
    repeat (3) @(negedge clk);
    chk({out_chan, out_period, out_diff, out_sample} == held, "R10 head stable",
        {out_chan, out_period, out_diff, out_sample}, held);
    chk(expq.size() == FDEPTH, "R8 model holds full fifo", 64'(expq.size()), 64'(FDEPTH));
    out_ready = 1'b1;
    drain();
    chk(ovf == 1'b1, "R8 ovf sticky", 64'(ovf), 64'h1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin bprev[i] = '0; bprimed[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prime();
    t_full_frames();
    t_threshold();
    t_extremes();
    t_resync();
    t_idle();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule